// File: doc/BRIEF.md
# Multi-output fractional reference clock generator

This block takes one fast PLL clock and produces four reference clock-enable streams in that clock domain. Each stream runs at an average rate of the input rate times 18 divided by its own 6-bit fraction. A fraction of 18 gives the full input rate, and a fraction of 35 gives a little over half of it. For example, a fraction of 30 on a 480 MHz input gives 288 MHz on average. Downstream logic uses each enable to qualify its flops, so the block never switches a clock net.

All four lanes share one 32-bit control word. Each lane owns one byte of it, holding a fraction field and a gate bit. The word is written over a simple register bus through four address aliases: a plain write, a bit set, a bit clear and a bit toggle. With the set, clear and toggle aliases, software can start, stop or adjust one lane without disturbing the others.

Each lane uses a running accumulator. A fraction outside the legal range stops the lane and raises that lane's error flag. A new fraction written while the lane runs is adopted only at the lane's next output pulse, so the pulse in progress keeps its spacing.

Top module: `frac_ref_gen`

## Requirements
- R1: Lane i is written in a single bus write that leaves it running with a legal fraction f, after it was gated. Over the N cycles starting with the second rising edge after that write, clk_en_o[i] is high in exactly floor(18*N/f) cycles.
- R2: Lane i occupies byte i of the control word. Bits [8i+5:8i] hold the fraction and bit 8i+7 holds the gate. Bit 8i+6 is reserved: it ignores writes and always reads 0.
- R3: While reset is asserted and after it is released, rdata_o reads 32'h92929292, which is every lane at fraction 18 and gated. clk_en_o and frac_err_o are 0.
- R4: A write with wr_en_i=1 is decoded from addr_i. Address 0 replaces the word, 1 ORs wdata_i in, 2 clears the bits that are 1 in wdata_i, and 3 inverts those bits. The result is visible on rdata_o after that rising edge.
- R5: A gate bit of 1 stops its lane. From the second rising edge after the gate is set, clk_en_o for that lane stays 0.
- R6: Fraction 18 makes the lane pulse on every cycle. Fraction 35 is the slowest legal setting.
- R7: A fraction below 18 or above 35 raises frac_err_o for that lane right after the write edge. clk_en_o for that lane stays 0 from the following edge on.
- R8: A fraction changed while the lane runs takes effect at the lane's next pulse. The long-run pulse count then follows the new fraction.
- R9: Lanes are independent. Gating or changing one lane does not stop the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast PLL clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Alias select: 0 plain, 1 set, 2 clear, 3 toggle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Current control word |
| clk_en_o | output | 4 | Per-lane clock-enable pulses |
| frac_err_o | output | 4 | Per-lane illegal-fraction flag |

## Verification
A register write lands on rdata_o and frac_err_o at its capturing edge. The bench therefore reads both at the falling edge right after that edge. The enable outputs are registered behind the control word, so the first enable that can reflect a write appears after the second rising edge. Pulse counts are taken over exactly N falling-edge samples that start after that edge, and are compared with floor(18*N/f). For a mid-run fraction change the new fraction is adopted at a pulse boundary rather than at the write, so that count is allowed one cycle of slack.

// File: rtl/frac_ref_pkg.sv
package frac_ref_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } bus_op_e;
endpackage

// File: rtl/frac_ref_regs.sv
module frac_ref_regs
  import frac_ref_pkg::*;
#(
  parameter int N_OUT    = 4,
  parameter int FRAC_W   = 6,
  parameter int FRAC_RST = 18,
  localparam int LANE_W  = FRAC_W + 2,
  localparam int DATA_W  = N_OUT * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] word_o
);
  function automatic logic [DATA_W-1:0] lane_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_OUT; i++) begin
      m[i*LANE_W +: FRAC_W]  = '1;
      m[i*LANE_W + LANE_W-1] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] reset_word();
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < N_OUT; i++) begin
      w[i*LANE_W +: FRAC_W]  = FRAC_W'(FRAC_RST);
      w[i*LANE_W + LANE_W-1] = 1'b1;
    end
    return w;
  endfunction

  localparam logic [DATA_W-1:0] MASK    = lane_mask();
  localparam logic [DATA_W-1:0] RST_VAL = reset_word();

  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (wr_en_i) begin
      unique case (bus_op_e'(addr_i))
        OP_WRITE: word_d = wdata_i;
        OP_SET:   word_d = word_q | wdata_i;
        OP_CLR:   word_d = word_q & ~wdata_i;
        OP_TOG:   word_d = word_q ^ wdata_i;
        default:  word_d = word_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= RST_VAL;
    else         word_q <= word_d & MASK;
  end

  assign word_o = word_q;
endmodule

// File: rtl/frac_ref_lane.sv
module frac_ref_lane #(
  parameter int FRAC_W   = 6,
  parameter int MUL      = 18,
  parameter int FRAC_MIN = 18,
  parameter int FRAC_MAX = 35,
  localparam int ACC_W   = FRAC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              gate_i,
  output logic              en_o,
  output logic              err_o
);
  localparam logic [FRAC_W-1:0] LO  = FRAC_W'(FRAC_MIN);
  localparam logic [FRAC_W-1:0] HI  = FRAC_W'(FRAC_MAX);
  localparam logic [ACC_W-1:0]  INC = ACC_W'(MUL);

  logic [ACC_W-1:0]  acc_q, sum;
  logic [FRAC_W-1:0] act_q, eff;
  logic              fresh_q, en_q, run, hit;

  assign err_o = (frac_i < LO) || (frac_i > HI);
  assign run   = !gate_i && !err_o;
  // the first step after a start uses the programmed value directly
  assign eff   = fresh_q ? frac_i : act_q;
  assign sum   = acc_q + INC;
  assign hit   = sum >= {1'b0, eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      act_q   <= LO;
      fresh_q <= 1'b1;
      en_q    <= 1'b0;
    end else if (!run) begin
      acc_q   <= '0;
      fresh_q <= 1'b1;
      en_q    <= 1'b0;
    end else begin
      fresh_q <= 1'b0;
      en_q    <= hit;
      acc_q   <= hit ? sum - {1'b0, eff} : sum;
      if (hit || fresh_q) act_q <= frac_i;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/frac_ref_gen.sv
module frac_ref_gen #(
  parameter int N_OUT    = 4,
  parameter int FRAC_W   = 6,
  parameter int MUL      = 18,
  parameter int FRAC_MIN = 18,
  parameter int FRAC_MAX = 35,
  localparam int LANE_W  = FRAC_W + 2,
  localparam int DATA_W  = N_OUT * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_OUT-1:0]  clk_en_o,
  output logic [N_OUT-1:0]  frac_err_o
);
  logic [DATA_W-1:0] word;

  frac_ref_regs #(
    .N_OUT(N_OUT), .FRAC_W(FRAC_W), .FRAC_RST(FRAC_MIN)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .word_o(word)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_lane
    frac_ref_lane #(
      .FRAC_W(FRAC_W), .MUL(MUL), .FRAC_MIN(FRAC_MIN), .FRAC_MAX(FRAC_MAX)
    ) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .frac_i(word[g*LANE_W +: FRAC_W]),
      .gate_i(word[g*LANE_W + LANE_W-1]),
      .en_o  (clk_en_o[g]),
      .err_o (frac_err_o[g])
    );
  end

  assign rdata_o = word;
endmodule

// File: rtl/frac_ref_gen_chk.sv
module frac_ref_gen_chk #(
  parameter int N_OUT  = 4,
  parameter int FRAC_W = 6,
  localparam int LANE_W = FRAC_W + 2,
  localparam int DATA_W = N_OUT * LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_OUT-1:0]  clk_en_o,
  input logic [N_OUT-1:0]  frac_err_o
);
  // R4
  plain_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == 2'd0 |=> (rdata_o | $past(wdata_i)) == $past(wdata_i) | rdata_o
      && (rdata_o & ~$past(wdata_i)) == '0);
  // R4
  set_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == 2'd1 |=> (rdata_o & $past(rdata_o)) == $past(rdata_o));
  // R4
  clr_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == 2'd2 |=> (rdata_o & $past(wdata_i)) == '0);
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rdata_o));

  for (genvar g = 0; g < N_OUT; g++) begin : g_lane
    // R2
    reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rdata_o[g*LANE_W + LANE_W-2]);
    // R5
    gate_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rdata_o[g*LANE_W + LANE_W-1]) |-> !clk_en_o[g]);
    // R7
    err_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frac_err_o[g] |=> !clk_en_o[g]);
  end
endmodule

bind frac_ref_gen frac_ref_gen_chk #(.N_OUT(N_OUT), .FRAC_W(FRAC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .clk_en_o(clk_en_o),
  .frac_err_o(frac_err_o)
);

// File: tb/frac_ref_gen_bench.sv
module frac_ref_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  clk_en, frac_err;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic [31:0] model = 32'h92929292;
  localparam logic [31:0] MASK = 32'hBFBFBFBF;
  int cnt [4];

  frac_ref_gen u_frac_ref_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .clk_en_o(clk_en), .frac_err_o(frac_err)
  );

  always #2.5 clk = ~clk;

  function automatic int exp_cnt(int f, int n);
    return (18 * n) / f;
  endfunction

  function automatic logic [31:0] pack(int f0, int f1, int f2, int f3, logic [3:0] gate);
    logic [31:0] w;
    w = '0;
    w[5:0] = 6'(f0); w[13:8] = 6'(f1); w[21:16] = 6'(f2); w[29:24] = 6'(f3);
    w[7] = gate[0]; w[15] = gate[1]; w[23] = gate[2]; w[31] = gate[3];
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bus_wr(logic [1:0] op, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = op; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    case (op)
      2'd0: model = d;
      2'd1: model = model | d;
      2'd2: model = model & ~d;
      default: model = model ^ d;
    endcase
    model = model & MASK;
  endtask

  task automatic count(int n);
    for (int l = 0; l < 4; l++) cnt[l] = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int l = 0; l < 4; l++) cnt[l] += int'(clk_en[l]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    int f [4];
    int n;
    void'($urandom(32'h5eed_0c1c));
    repeat (3) @(negedge clk);
    // R3 during and after reset
    chk("R3 rdata in reset", int'(rdata), int'(32'h92929292));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 rdata after reset", int'(rdata), int'(32'h92929292));
    chk("R3 clk_en", int'(clk_en), 0);
    chk("R3 frac_err", int'(frac_err), 0);

    // R4 R2 random alias traffic against register model
    for (int k = 0; k < 150; k++) begin
      bus_wr(2'($urandom % 4), $urandom);
      chk("R4 R2 alias result", int'(rdata), int'(model));
    end

    // R1 R6 R9 four lanes together
    bus_wr(2'd0, pack(18, 18, 18, 18, 4'hF));
    bus_wr(2'd0, pack(18, 24, 30, 35, 4'h0));
    chk("R1 first sample idle", int'(clk_en), 0);
    count(360);
    chk("R6 lane0 f18", cnt[0], 360);
    chk("R1 lane1 f24", cnt[1], exp_cnt(24, 360));
    chk("R1 lane2 f30", cnt[2], exp_cnt(30, 360));
    chk("R6 lane3 f35", cnt[3], exp_cnt(35, 360));

    // R8 change lane0 to 27 while running
    bus_wr(2'd0, pack(27, 24, 30, 35, 4'h0));
    count(270);
    chk_rng("R8 lane0 after change", cnt[0], 179, 181);

    // R5 R9 gate lane2 through set alias
    bus_wr(2'd1, 32'h0080_0000);
    @(negedge clk);
    count(60);
    chk("R5 lane2 gated", cnt[2], 0);
    chk_rng("R9 lane3 still runs", cnt[3], 29, 31);

    // R7 illegal fractions
    bus_wr(2'd0, pack(18, 40, 17, 35, 4'h0));
    chk("R7 err flags", int'(frac_err), 4'b0110);
    count(50);
    chk("R7 lane1 silent", cnt[1], 0);
    chk("R7 lane2 silent", cnt[2], 0);
    chk("R9 lane0 unaffected", cnt[0], 50);
    bus_wr(2'd0, pack(35, 18, 36, 0, 4'h0));
    chk("R7 boundary flags", int'(frac_err), 4'b1100);

    // R1 random legal fractions and windows
    for (int it = 0; it < 6; it++) begin
      for (int l = 0; l < 4; l++) f[l] = 18 + int'($urandom % 18);
      n = 100 + int'($urandom % 300);
      bus_wr(2'd0, pack(18, 18, 18, 18, 4'hF));
      bus_wr(2'd0, pack(f[0], f[1], f[2], f[3], 4'h0));
      count(n);
      for (int l = 0; l < 4; l++) chk("R1 random window", cnt[l], exp_cnt(f[l], n));
    end

    finish_run();
  end
endmodule